// File: doc/BRIEF.md
# Framebuffer Interrupt Control Register File

This block is a small byte-wide register file in a 32-byte window. It holds the settings that govern a framebuffer's vertical-sync interrupt. Software reaches it with single-byte reads and writes. The upper half of the window holds a control byte with an interrupt-enable bit and a status byte. The status byte carries a pending flag plus fixed identification bits. The remaining fourteen bytes are plain storage for cursor and video-control settings. The lower half of the window belongs to neighbouring logic: here it reads as zero and ignores writes.

The video timing logic delivers a one-cycle end-of-frame pulse. When interrupts are enabled, that pulse latches the pending flag, and the flag drives a level interrupt output. The output stays high until software writes any value to the status byte. Reads are combinational from the address. Writes take effect on the next rising clock edge.

Top module: `fb_irq_regs`

## Requirements
- R1: After reset the irq output is 0, the control byte and all storage bytes read 0x00, and the status byte reads 0x61.
- R2: A write to offset 0x10 stores all 8 data bits, and a read of 0x10 returns them unchanged.
- R3: A read of offset 0x11 returns bit 7 equal to the pending flag and bits 6..0 equal to 0x61 (bits 6, 5 and 0 set), whatever the pending state.
- R4: An end-of-frame pulse while control bit 7 is 1 sets the pending flag and raises irq at the next clock edge. A pulse while control bit 7 is 0 changes nothing.
- R5: A write of any data value to offset 0x11 clears the pending flag and lowers irq at the next edge. If the flag is already clear, such a write changes nothing.
- R6: irq is a registered level equal to the pending flag, and it stays high across later frames until a clearing write.
- R7: When a clearing write and an enabled end-of-frame pulse fall in the same cycle, the set wins and irq stays high.
- R8: Offsets 0x12 to 0x1F are independent read/write bytes, each stored at index (offset minus 0x10).
- R9: Offsets 0x00 to 0x0F read as 0x00, and writes to them leave every register unchanged.
- R10: The enable used by an end-of-frame pulse is the control value held before that clock edge. A control write in the same cycle as the pulse does not affect that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 5 | Byte offset within the window |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| frame_end | input | 1 | One-cycle end-of-frame pulse from video timing |
| irq | output | 1 | Level interrupt, high while the pending flag is set |

## Verification
Directed sequences cover the following cases:
- frames with the enable bit off against frames with it on, which separates the gating from the latching;
- repeated frames while the flag is pending, which shows the level holds;
- clearing writes with both zero and non-zero data, and a clearing write while nothing is pending;
- a clearing write in the same cycle as an enabled frame, which exposes the priority;
- a control write in the same cycle as a frame, which shows which enable value is sampled.

Distinct patterns written across every storage byte and into the lower half catch aliasing between indices and writes that leak into other registers. A seeded random mix of writes, frames and reads over the whole window then compares every read and the irq level against a reference model in the bench.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
    parameter int ADDR_W = 5;
    parameter int DATA_W = 8;
    localparam int IDX_W    = ADDR_W - 1;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int CTRL_IDX = 0;
    localparam int STAT_IDX = 1;
    localparam int IRQ_EN_BIT = DATA_W - 1;
    localparam int PEND_BIT   = DATA_W - 1;
    localparam logic [DATA_W-1:0] ID_BITS = DATA_W'(8'h61);

    typedef struct packed {
        logic             hit_ctrl;
        logic             hit_stat;
        logic             hit_store;
        logic [IDX_W-1:0] idx;
    } fbr_dec_t;

    function automatic logic [DATA_W-1:0] status_view(input logic pend);
        logic [DATA_W-1:0] v;
        v = ID_BITS;
        v[PEND_BIT] = pend;
        return v;
    endfunction
endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
    import fbr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output fbr_dec_t          dec
);
    logic upper;
    assign upper = addr[ADDR_W-1];

    always_comb begin
        dec.idx       = addr[IDX_W-1:0];
        dec.hit_ctrl  = upper && (int'(addr[IDX_W-1:0]) == CTRL_IDX);
        dec.hit_stat  = upper && (int'(addr[IDX_W-1:0]) == STAT_IDX);
        dec.hit_store = upper && !dec.hit_ctrl && !dec.hit_stat;
    end
endmodule

// File: rtl/fbr_store.sv
module fbr_store
    import fbr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
        if (i == STAT_IDX) begin : g_hole
            assign regs_flat[i*DATA_W +: DATA_W] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && (int'(wr_idx) == i))
                    q <= wdata;
            end
            assign regs_flat[i*DATA_W +: DATA_W] = q;
        end
    end
endmodule

// File: rtl/fbr_pending.sv
module fbr_pending (
    input  logic clk,
    input  logic rst,
    input  logic frame_end,
    input  logic irq_en,
    input  logic clr_req,
    output logic pend
);
    logic set_req;
    assign set_req = frame_end && irq_en;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (set_req)
            pend <= 1'b1;
        else if (clr_req)
            pend <= 1'b0;
    end
endmodule

// File: rtl/fb_irq_regs.sv
module fb_irq_regs
    import fbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_end,
    output logic              irq
);
    fbr_dec_t                   dec;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic [DATA_W-1:0]          ctrl_q;
    logic                       pend;

    fbr_decode u_dec (.addr(addr), .dec(dec));

    fbr_store u_store (
        .clk(clk), .rst(rst),
        .we(wr_en && (dec.hit_ctrl || dec.hit_store)),
        .wr_idx(dec.idx), .wdata(wr_data), .regs_flat(regs_flat)
    );

    assign ctrl_q = regs_flat[CTRL_IDX*DATA_W +: DATA_W];

    fbr_pending u_pend (
        .clk(clk), .rst(rst), .frame_end(frame_end),
        .irq_en(ctrl_q[IRQ_EN_BIT]),
        .clr_req(wr_en && dec.hit_stat),
        .pend(pend)
    );

    assign irq = pend;

    always_comb begin
        if (dec.hit_stat)
            rd_data = status_view(pend);
        else if (dec.hit_ctrl || dec.hit_store)
            rd_data = regs_flat[dec.idx*DATA_W +: DATA_W];
        else
            rd_data = '0;
    end
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker
    import fbr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              frame_end,
    input logic              irq,
    input logic              irq_en
);
    logic stat_wr;
    logic set_ev;
    assign stat_wr = wr_en && (addr == ADDR_W'(NUM_REGS + STAT_IDX));
    assign set_ev  = frame_end && irq_en;

    p_reset_low_r1: assert property (@(posedge clk) rst |=> !irq);

    p_status_view_r3: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(NUM_REGS + STAT_IDX)) |->
            (rd_data[PEND_BIT] == irq && rd_data[PEND_BIT-1:0] == ID_BITS[PEND_BIT-1:0]));

    p_set_r4: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> irq);

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        (!irq && !set_ev) |=> !irq);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !set_ev) |=> !irq);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_wr) |=> irq);

    p_low_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !addr[ADDR_W-1] |-> (rd_data == '0));
endmodule

bind fb_irq_regs fbr_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .rd_data(rd_data),
    .frame_end(frame_end), .irq(irq), .irq_en(ctrl_q[7])
);

// File: tb/fb_irq_regs_bench.sv
module fb_irq_regs_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       frame_end = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_reg [16];
    logic       m_pend;

    always #5 clk = ~clk;

    fb_irq_regs u_fb_irq_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .frame_end(frame_end), .irq(irq)
    );

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        if (a < 5'h10) return 8'h00;
        if (a == 5'h11) return 8'h61 | {m_pend, 7'b0};
        return m_reg[a - 5'h10];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        m_pend = 1'b0;
    endtask

    task automatic step(input bit we, input logic [4:0] a, input logic [7:0] d, input bit fe);
        bit set_e;
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; frame_end = fe;
        @(posedge clk);
        set_e = fe && m_reg[0][7];
        if (set_e) m_pend = 1'b1;
        else if (we && a == 5'h11) m_pend = 1'b0;
        if (we && a >= 5'h10 && a != 5'h11) m_reg[a - 5'h10] = d;
    endtask

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic check_read(input logic [4:0] a, input string tag);
        @(negedge clk);
        wr_en = 1'b0; frame_end = 1'b0; addr = a;
        #1;
        check(rd_data, exp_read(a), tag);
        check({7'b0, irq}, {7'b0, m_pend}, {tag, " irq"});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        for (int a = 16; a < 32; a++) check_read(5'(a), "R1 reset");

        // R2 control byte round trip
        step(1, 5'h10, 8'h5A, 0); check_read(5'h10, "R2 ctrl 5A");
        step(1, 5'h10, 8'h00, 0); check_read(5'h10, "R2 ctrl 00");

        // R8 storage bytes with distinct values
        for (int a = 18; a < 32; a++) step(1, 5'(a), 8'(a * 13 + 7), 0);
        for (int a = 18; a < 32; a++) check_read(5'(a), "R8 store");

        // R9 low half ignored and reads zero
        for (int a = 0; a < 16; a++) step(1, 5'(a), 8'hFF, 1);
        for (int a = 0; a < 32; a++) check_read(5'(a), "R9 low half");

        // R4 disabled frame has no effect
        step(0, 5'h00, 8'h00, 1); check_read(5'h11, "R4 disabled");

        // R10 enable written in same cycle as frame is not used
        step(1, 5'h10, 8'h80, 1); check_read(5'h11, "R10 same cycle");

        // R4 enabled frame sets pending
        step(0, 5'h00, 8'h00, 1); check_read(5'h11, "R4 set");
        // R6 holds over frames and idle cycles
        step(0, 5'h00, 8'h00, 1); step(0, 5'h12, 8'h00, 0);
        check_read(5'h11, "R6 hold");
        // R3 status view with pending
        check(rd_data, 8'hE1, "R3 status pending");

        // R5 clear with nonzero data
        step(1, 5'h11, 8'h3C, 0); check_read(5'h11, "R5 clear");
        check(rd_data, 8'h61, "R3 status idle");
        // R5 clear when idle does nothing
        step(1, 5'h11, 8'hFF, 0); check_read(5'h11, "R5 idle write");
        check_read(5'h10, "R5 ctrl untouched");

        // R7 set beats clear
        step(0, 5'h00, 8'h00, 1);
        step(1, 5'h11, 8'h00, 1); check_read(5'h11, "R7 set wins");
        step(1, 5'h11, 8'h00, 0); check_read(5'h11, "R5 clear zero data");

        // random mix
        for (int k = 0; k < 500; k++) begin
            logic [4:0] ra;
            logic [7:0] rd;
            bit rw, rf;
            ra = 5'($urandom_range(0, 31));
            if ($urandom_range(0, 3) == 0) ra = 5'h11;
            else if ($urandom_range(0, 5) == 0) ra = 5'h10;
            rd = 8'($urandom);
            rw = $urandom_range(0, 1) == 1;
            rf = $urandom_range(0, 3) == 0;
            step(rw, ra, rd, rf);
            check_read(5'($urandom_range(0, 31)), "R2 R3 R4 R5 R8 random");
        end

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        @(posedge clk); model_reset();
        @(negedge clk); rst = 1'b0;
        check_read(5'h11, "R1 rereset status");
        check_read(5'h10, "R1 rereset ctrl");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule